// File: doc/BRIEF.md
# Per-Thread Branch Stream Tagger

This block tracks, for each hardware thread, the epoch of the instruction stream that the execute stage currently accepts. It also tracks the prediction tag of the most recently committed instruction. When execute asks for a fetch redirect, the block builds a branch record. The record carries the reason, the thread, the stream epoch, a prediction tag and the target. It is registered and appears on the cycle after the request.

Only redirect reasons that start a new stream move a thread's epoch forward. Reasons that merely inform fetch still produce a record, but they keep the epoch. For a redirect that has no instruction behind it, such as an interrupt or a fetch halt, the record's prediction tag falls back to the last tag the thread committed.

Two combinational filters compare an instruction's stream tag with its thread's current epoch. One sits at issue and one at commit, and each gives a keep or discard flag. A kept commit also refreshes the thread's remembered prediction tag. Epochs are counters modulo 2^SEQ_W and are only ever tested for equality.

Top module: `branch_stream_tagger`

## Requirements
- R1: After reset, rec_valid is 0, every thread's stream epoch equals FIRST_STREAM (default 1), and every thread's remembered prediction tag is 0.
- R2: An accepted request whose reason is stream-changing advances the epoch of thread br_tid by one and leaves every other thread's epoch unchanged. With the default STREAM_CHANGE_SET of 8'hF0, the stream-changing reasons are codes 4, 5, 6 and 7. The new epoch is in use from the next cycle.
- R3: An accepted request with reason code 1, 2 or 3 produces a record and leaves the epoch unchanged.
- R4: Reason code 0 (NO_BRANCH) produces no record: rec_valid is 0 on the next cycle, and no epoch changes.
- R5: One cycle after an accepted request, rec_valid is 1, and rec_reason, rec_tid and rec_target equal the request's values. rec_stream holds the thread's epoch after any advance made by that request.
- R6: rec_pred equals br_inst_pred when br_has_inst is 1. Otherwise it equals the thread's remembered prediction tag as of the request cycle.
- R7: iss_keep is 1 in the same cycle exactly when iss_valid is 1 and iss_stream equals the current epoch of thread iss_tid. Otherwise the instruction is to be discarded.
- R8: cmt_keep follows the same rule for cmt_valid, cmt_tid and cmt_stream. A kept commit sets that thread's remembered prediction tag to cmt_pred from the next cycle. A discarded commit does not change it.
- R9: While br_hold is 1, a request is ignored: no record appears on the next cycle and no epoch changes.
- R10: An epoch wraps from 2^SEQ_W-1 to 0, so that 2^SEQ_W stream-changing redirects return it to its starting value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_req | input | 1 | Redirect request this cycle |
| br_hold | input | 1 | A record already occupies the outgoing path; the request is ignored |
| br_tid | input | TID_W | Thread of the redirect |
| br_reason | input | REASON_W | Redirect reason code |
| br_target | input | TGT_W | Redirect target address |
| br_has_inst | input | 1 | The redirect is caused by an instruction |
| br_inst_pred | input | PRED_W | Prediction tag of that instruction |
| iss_valid | input | 1 | An instruction is presented at issue |
| iss_tid | input | TID_W | Its thread |
| iss_stream | input | SEQ_W | Its stream tag |
| iss_keep | output | 1 | Keep (1) or discard (0) at issue |
| cmt_valid | input | 1 | An instruction is presented at commit |
| cmt_tid | input | TID_W | Its thread |
| cmt_stream | input | SEQ_W | Its stream tag |
| cmt_pred | input | PRED_W | Its prediction tag |
| cmt_keep | output | 1 | Keep (1) or discard (0) at commit |
| rec_valid | output | 1 | Branch record valid |
| rec_reason | output | REASON_W | Record reason |
| rec_tid | output | TID_W | Record thread |
| rec_stream | output | SEQ_W | Record stream epoch |
| rec_pred | output | PRED_W | Record prediction tag |
| rec_target | output | TGT_W | Record target |

## Verification
The branch record is due one rising edge after the request. Epoch and prediction-tag updates take effect on that same edge. The issue and commit flags are due in the request cycle itself. The bench applies every stimulus just after a falling edge. It reads the keep flags one nanosecond later, before the next rising edge. It reads the record one nanosecond after the rising edge that registers it. Any effect on the epochs is checked through the keep flags of the cycles that follow.

// File: rtl/branch_stream_tagger.sv
module branch_stream_tagger #(
  parameter int NTHREADS = 4,
  parameter int SEQ_W = 8,
  parameter int PRED_W = 8,
  parameter int TGT_W = 32,
  parameter int REASON_W = 3,
  parameter int NO_BRANCH = 0,
  parameter logic [(1<<REASON_W)-1:0] STREAM_CHANGE_SET = 'hF0,
  parameter logic [SEQ_W-1:0] FIRST_STREAM = 1,
  localparam int TID_W = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                br_req,
  input  logic                br_hold,
  input  logic [TID_W-1:0]    br_tid,
  input  logic [REASON_W-1:0] br_reason,
  input  logic [TGT_W-1:0]    br_target,
  input  logic                br_has_inst,
  input  logic [PRED_W-1:0]   br_inst_pred,
  input  logic                iss_valid,
  input  logic [TID_W-1:0]    iss_tid,
  input  logic [SEQ_W-1:0]    iss_stream,
  output logic                iss_keep,
  input  logic                cmt_valid,
  input  logic [TID_W-1:0]    cmt_tid,
  input  logic [SEQ_W-1:0]    cmt_stream,
  input  logic [PRED_W-1:0]   cmt_pred,
  output logic                cmt_keep,
  output logic                rec_valid,
  output logic [REASON_W-1:0] rec_reason,
  output logic [TID_W-1:0]    rec_tid,
  output logic [SEQ_W-1:0]    rec_stream,
  output logic [PRED_W-1:0]   rec_pred,
  output logic [TGT_W-1:0]    rec_target
);

  logic [NTHREADS-1:0][SEQ_W-1:0]  stream_q;
  logic [NTHREADS-1:0][PRED_W-1:0] last_pred_q;

  logic              accept, advance;
  logic [SEQ_W-1:0]  new_stream;
  logic [PRED_W-1:0] pick_pred;

  assign accept     = br_req && !br_hold && (br_reason != REASON_W'(NO_BRANCH));
  assign advance    = STREAM_CHANGE_SET[br_reason];
  assign new_stream = stream_q[br_tid] + SEQ_W'(advance);
  assign pick_pred  = br_has_inst ? br_inst_pred : last_pred_q[br_tid];

  assign iss_keep = iss_valid && (iss_stream == stream_q[iss_tid]);
  assign cmt_keep = cmt_valid && (cmt_stream == stream_q[cmt_tid]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < NTHREADS; t++) begin
        stream_q[t]    <= FIRST_STREAM;
        last_pred_q[t] <= '0;
      end
      rec_valid  <= 1'b0;
      rec_reason <= '0;
      rec_tid    <= '0;
      rec_stream <= '0;
      rec_pred   <= '0;
      rec_target <= '0;
    end else begin
      if (accept && advance)
        stream_q[br_tid] <= new_stream;
      if (cmt_keep)
        last_pred_q[cmt_tid] <= cmt_pred;
      rec_valid <= accept;
      if (accept) begin
        rec_reason <= br_reason;
        rec_tid    <= br_tid;
        rec_stream <= new_stream;
        rec_pred   <= pick_pred;
        rec_target <= br_target;
      end
    end
  end

endmodule

// File: rtl/branch_stream_tagger_chk.sv
module branch_stream_tagger_chk #(
  parameter int NTHREADS = 4,
  parameter int SEQ_W = 8,
  parameter int PRED_W = 8,
  parameter int TGT_W = 32,
  parameter int REASON_W = 3,
  parameter int NO_BRANCH = 0,
  parameter logic [(1<<REASON_W)-1:0] STREAM_CHANGE_SET = 'hF0,
  parameter int TID_W = 2
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            br_req,
  input logic                            br_hold,
  input logic [TID_W-1:0]                br_tid,
  input logic [REASON_W-1:0]             br_reason,
  input logic [TGT_W-1:0]                br_target,
  input logic                            br_has_inst,
  input logic [PRED_W-1:0]               br_inst_pred,
  input logic                            rec_valid,
  input logic [REASON_W-1:0]             rec_reason,
  input logic [TID_W-1:0]                rec_tid,
  input logic [SEQ_W-1:0]                rec_stream,
  input logic [PRED_W-1:0]               rec_pred,
  input logic [TGT_W-1:0]                rec_target,
  input logic [NTHREADS-1:0][SEQ_W-1:0]  stream_q
);

  logic go, moves;
  assign go    = br_req && !br_hold && (br_reason != REASON_W'(NO_BRANCH));
  assign moves = STREAM_CHANGE_SET[br_reason];

  a_r4_null_no_record: assert property (@(posedge clk) disable iff (!rst_n)
    (br_req && br_reason == REASON_W'(NO_BRANCH)) |=> !rec_valid);

  a_r9_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    br_hold |=> !rec_valid);

  a_r5_record_fields: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (rec_valid && rec_tid == $past(br_tid) &&
            rec_reason == $past(br_reason) && rec_target == $past(br_target)));

  a_r6_inst_pred: assert property (@(posedge clk) disable iff (!rst_n)
    (go && br_has_inst) |=> rec_pred == $past(br_inst_pred));

  a_r2_epoch_step: assert property (@(posedge clk) disable iff (!rst_n)
    (go && moves) |=> rec_stream == SEQ_W'($past(stream_q[br_tid]) + 1'b1));

  a_r3_epoch_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !(go && moves) |=> $stable(stream_q));

endmodule

bind branch_stream_tagger branch_stream_tagger_chk #(
  .NTHREADS(NTHREADS), .SEQ_W(SEQ_W), .PRED_W(PRED_W), .TGT_W(TGT_W),
  .REASON_W(REASON_W), .NO_BRANCH(NO_BRANCH),
  .STREAM_CHANGE_SET(STREAM_CHANGE_SET), .TID_W(TID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .br_req(br_req), .br_hold(br_hold),
  .br_tid(br_tid), .br_reason(br_reason), .br_target(br_target),
  .br_has_inst(br_has_inst), .br_inst_pred(br_inst_pred),
  .rec_valid(rec_valid), .rec_reason(rec_reason), .rec_tid(rec_tid),
  .rec_stream(rec_stream), .rec_pred(rec_pred), .rec_target(rec_target),
  .stream_q(stream_q)
);

// File: tb/tb_branch_stream_tagger.sv
`timescale 1ns/1ps
module tb_branch_stream_tagger;
  localparam int NT = 4, SW = 8, PW = 8, TW = 32, RW = 3, IW = 2;

  logic clk = 0, rst_n = 0;
  logic br_req = 0, br_hold = 0, br_has_inst = 0;
  logic [IW-1:0] br_tid = 0;
  logic [RW-1:0] br_reason = 0;
  logic [TW-1:0] br_target = 0;
  logic [PW-1:0] br_inst_pred = 0;
  logic iss_valid = 0, cmt_valid = 0;
  logic [IW-1:0] iss_tid = 0, cmt_tid = 0;
  logic [SW-1:0] iss_stream = 0, cmt_stream = 0;
  logic [PW-1:0] cmt_pred = 0;
  logic iss_keep, cmt_keep, rec_valid;
  logic [RW-1:0] rec_reason;
  logic [IW-1:0] rec_tid;
  logic [SW-1:0] rec_stream;
  logic [PW-1:0] rec_pred;
  logic [TW-1:0] rec_target;

  always #2.5 clk = ~clk;

  branch_stream_tagger dut (
    .clk(clk), .rst_n(rst_n), .br_req(br_req), .br_hold(br_hold),
    .br_tid(br_tid), .br_reason(br_reason), .br_target(br_target),
    .br_has_inst(br_has_inst), .br_inst_pred(br_inst_pred),
    .iss_valid(iss_valid), .iss_tid(iss_tid), .iss_stream(iss_stream),
    .iss_keep(iss_keep), .cmt_valid(cmt_valid), .cmt_tid(cmt_tid),
    .cmt_stream(cmt_stream), .cmt_pred(cmt_pred), .cmt_keep(cmt_keep),
    .rec_valid(rec_valid), .rec_reason(rec_reason), .rec_tid(rec_tid),
    .rec_stream(rec_stream), .rec_pred(rec_pred), .rec_target(rec_target));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [SW-1:0] exp_stream [NT];
  logic [PW-1:0] exp_last [NT];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic branch(input int tid, input int reason, input logic [TW-1:0] tgt,
                        input bit has, input logic [PW-1:0] pred, input bit hold);
    bit acc;
    logic [PW-1:0] ep;
    @(negedge clk);
    br_req = 1; br_hold = hold; br_tid = IW'(tid); br_reason = RW'(reason);
    br_target = tgt; br_has_inst = has; br_inst_pred = pred;
    acc = !hold && reason != 0;
    ep = has ? pred : exp_last[tid];
    if (acc && reason >= 4) exp_stream[tid] = exp_stream[tid] + 1'b1;
    @(posedge clk); #1;
    br_req = 0; br_hold = 0;
    if (!acc) chk(hold ? "R9 record suppressed" : "R4 no record", rec_valid, 0);
    else begin
      chk("R5 rec_valid", rec_valid, 1);
      chk("R5 rec_reason", rec_reason, reason);
      chk("R5 rec_tid", rec_tid, tid);
      chk("R5 rec_target", rec_target, tgt);
      chk("R2 R3 rec_stream", rec_stream, exp_stream[tid]);
      chk("R6 rec_pred", rec_pred, ep);
    end
  endtask

  task automatic probe(input string tag, input int tid, input logic [SW-1:0] s, input bit exp);
    @(negedge clk);
    iss_valid = 1; iss_tid = IW'(tid); iss_stream = s;
    #1 chk(tag, iss_keep, exp);
    iss_valid = 0;
  endtask

  task automatic commit(input int tid, input logic [SW-1:0] s, input logic [PW-1:0] p);
    bit k;
    @(negedge clk);
    cmt_valid = 1; cmt_tid = IW'(tid); cmt_stream = s; cmt_pred = p;
    k = (s == exp_stream[tid]);
    #1 chk("R8 cmt_keep", cmt_keep, k);
    @(posedge clk); #1;
    cmt_valid = 0;
    if (k) exp_last[tid] = p;
  endtask

  task automatic t_reset();
    chk("R1 rec_valid after reset", rec_valid, 0);
    for (int t = 0; t < NT; t++) begin
      probe("R1 R7 first epoch kept", t, 8'd1, 1);
      probe("R7 wrong epoch discarded", t, 8'd2, 0);
    end
  endtask

  task automatic t_null();
    branch(0, 0, 32'h100, 1, 8'h11, 0);
    probe("R4 epoch unchanged", 0, exp_stream[0], 1);
  endtask

  task automatic t_informative();
    branch(0, 1, 32'h200, 1, 8'h33, 0);
    branch(0, 3, 32'h204, 1, 8'h34, 0);
    probe("R3 epoch unchanged", 0, 8'd1, 1);
  endtask

  task automatic t_stream_change();
    branch(1, 5, 32'h300, 1, 8'h40, 0);
    probe("R2 old epoch discarded", 1, 8'd1, 0);
    probe("R2 new epoch kept", 1, 8'd2, 1);
    probe("R2 other thread untouched", 0, 8'd1, 1);
    probe("R2 other thread untouched", 2, 8'd1, 1);
  endtask

  task automatic t_fallback();
    commit(2, 8'd1, 8'h5A);
    commit(2, 8'd9, 8'h77);
    branch(2, 6, 32'h400, 0, 8'hEE, 0);
    chk("R6 R8 fallback to last kept commit", rec_pred, 8'h5A);
    commit(2, 8'd1, 8'h12);
    probe("R8 stale commit epoch", 2, 8'd2, 1);
  endtask

  task automatic t_hold();
    branch(0, 7, 32'h500, 0, 8'h00, 1);
    probe("R9 epoch unchanged under hold", 0, 8'd1, 1);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < (1 << SW); i++) branch(3, 4, 32'h600 + i, 0, 8'h00, 0);
    chk("R10 epoch wrapped to start", exp_stream[3], 8'd1);
    probe("R10 start epoch kept after wrap", 3, 8'd1, 1);
    probe("R10 neighbour discarded after wrap", 3, 8'd0, 0);
  endtask

  initial begin
    for (int t = 0; t < NT; t++) begin exp_stream[t] = 8'd1; exp_last[t] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_null();
    t_informative();
    t_stream_change();
    t_fallback();
    t_hold();
    t_wrap();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule